// File: doc/BRIEF.md
# Byte-Lane Read-Modify-Write Write Controller

This block connects a requester that writes single bytes, halfwords or whole words to a storage array that only moves complete 64-bit words. A request gives a word address, eight byte-lane enables and 64 bits of write data. When only some lanes are enabled, the block reads the stored word into a holding register and replaces only the enabled lanes. It then writes the whole word back. When every lane is enabled there is nothing to keep, so the read is skipped and the word is written at once.

Reads always return the full 64-bit word, and the requester picks out the bytes it needs. A read answers with a single-cycle response strobe once the array's one-cycle latency has passed. The request port uses a valid/ready handshake. Ready drops for as long as an update is in flight, so a second request can never slip in between the read and the write-back of the first.

The storage is modelled inside the block as a synchronous word array with a registered read port.

Top module: `lane_rmw_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A write with all eight enables set stores `req_wdata` unchanged, performs no array read, and holds `req_ready` low for exactly one cycle after acceptance.
- R3: In a partial write, bit i of `req_be` controls byte lane i, which is data bits [8i+7:8i]. Enabled lanes take the new data and every other lane keeps its previous content.
- R4: A partial write runs read, merge and write-back in that order, keeping `req_ready` low for exactly three cycles after acceptance.
- R5: While an update is in flight no request is accepted. A request held at the port is taken once `req_ready` returns, and it observes the completed update.
- R6: A write with all eight enables clear changes nothing in the array and leaves `req_ready` high.
- R7: A read raises `rsp_valid` for exactly one cycle, on the second cycle after acceptance, with the whole stored word on `rsp_rdata`.
- R8: Writes never raise `rsp_valid`.
- R9: `req_addr` selects one word, and a write leaves every other word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | DATA_W/8 | Byte-lane enables for writes |
| req_wdata | input | DATA_W | Write data, lane i in bits [8i+7:8i] |
| rsp_valid | output | 1 | One-cycle strobe marking read data |
| rsp_rdata | output | DATA_W | Full word returned by a read |

## Verification
The assertions check the following on every cycle:
- the cycle-exact state sequences for full, partial and empty writes and for reads;
- that the array is never read and written in the same cycle;
- that the captured request stays frozen while busy;
- that every partial write-back keeps the unenabled lanes of the word it just read and takes the enabled lanes from the request.

Only the bench's scenarios can show that the stored contents are correct across requests. These scenarios also show that a word at one address survives writes to others, that an empty-enable write really leaves the word intact, and that a request held during a busy period sees the finished update.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MERGE = 2'd2,
    ST_WRITE = 2'd3
  } rmw_state_e;
endpackage

// File: rtl/rmw_word_ram.sv
module rmw_word_ram #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [0:DEPTH-1];

  // Single port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    if (re) q <= store[addr];
  end

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(we && re)); // R4
endmodule

// File: rtl/rmw_lane_merge.sv
module rmw_lane_merge #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]   old_word,
  input  logic [DATA_W-1:0]   new_word,
  input  logic [DATA_W/8-1:0] lane_en,
  output logic [DATA_W-1:0]   merged
);
  localparam int LANES = DATA_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[8*g +: 8] = lane_en[g] ? new_word[8*g +: 8] : old_word[8*g +: 8];
  end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W-1:0]   merged_word,
  output logic                req_ready,
  output logic                mem_re,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   hold_word,
  output logic [DATA_W/8-1:0] op_be,
  output logic [DATA_W-1:0]   op_wdata,
  output logic                rsp_valid
);
  localparam int LANES = DATA_W / 8;

  rmw_state_e        state;
  logic              op_write;
  logic [ADDR_W-1:0] op_addr;
  logic              accept;
  logic              all_lanes;
  logic              no_lanes;

  assign accept    = req_valid && req_ready;
  assign all_lanes = &req_be;
  assign no_lanes  = ~|req_be;

  assign req_ready = (state == ST_IDLE);
  assign mem_re    = (state == ST_READ);
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = op_addr;

  // Control path with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_write  <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= (state == ST_READ) && !op_write;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_write <= req_write;
            if (!req_write)     state <= ST_READ;
            else if (all_lanes) state <= ST_WRITE;
            else if (!no_lanes) state <= ST_READ;
          end
        end
        ST_READ:  state <= op_write ? ST_MERGE : ST_IDLE;
        ST_MERGE: state <= ST_WRITE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // Data path without reset
  always_ff @(posedge clk) begin
    if (state == ST_IDLE && accept) begin
      op_addr  <= req_addr;
      op_be    <= req_be;
      op_wdata <= req_wdata;
      if (req_write && all_lanes) hold_word <= req_wdata;
    end else if (state == ST_MERGE) begin
      hold_word <= merged_word;
    end
  end

  AST_FULL_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write && all_lanes) |=> (mem_we && !mem_re)); // R2
  AST_RMW_ORDER: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write && !all_lanes && !no_lanes) |=>
      mem_re ##1 (!mem_we && !req_ready) ##1 mem_we ##1 req_ready); // R4
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> ($stable(op_addr) && $stable(op_be) && $stable(op_wdata))); // R5
  AST_EMPTY_SKIP: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write && no_lanes) |=> (req_ready && !mem_re && !mem_we)); // R6
  AST_READ_RESP: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_write) |=> mem_re ##1 rsp_valid); // R7
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R7
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write) |=> !rsp_valid ##1 !rsp_valid); // R8

  initial begin
    AST_LANE_COUNT: assert (LANES * 8 == DATA_W); // R3
  end
endmodule

// File: rtl/lane_rmw_ctrl.sv
module lane_rmw_ctrl #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata
);
  localparam int LANES = DATA_W / 8;

  logic              mem_re;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] hold_word;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] merged_word;
  logic [LANES-1:0]  op_be;
  logic [DATA_W-1:0] op_wdata;
  logic [DATA_W-1:0] lane_mask;

  rmw_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_be      (req_be),
    .req_wdata   (req_wdata),
    .merged_word (merged_word),
    .req_ready   (req_ready),
    .mem_re      (mem_re),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .hold_word   (hold_word),
    .op_be       (op_be),
    .op_wdata    (op_wdata),
    .rsp_valid   (rsp_valid)
  );

  rmw_lane_merge #(.DATA_W(DATA_W)) u_merge (
    .old_word (ram_q),
    .new_word (op_wdata),
    .lane_en  (op_be),
    .merged   (merged_word)
  );

  rmw_word_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .re    (mem_re),
    .addr  (mem_addr),
    .wdata (hold_word),
    .q     (ram_q)
  );

  assign rsp_rdata = ram_q;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign lane_mask[8*g +: 8] = {8{op_be[g]}};
  end

  // Partial write-back: unenabled lanes come from the word just read,
  // enabled lanes from the request
  AST_MERGE_LANES: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !(&op_be)) |->
      (((hold_word ^ ram_q) & ~lane_mask) == '0) &&
      (((hold_word ^ op_wdata) & lane_mask) == '0)); // R3
endmodule

// File: tb/lane_rmw_ctrl_test.sv
`timescale 1ns/1ps
module lane_rmw_ctrl_test;
  localparam int DW = 64;
  localparam int AW = 6;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_be = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [DW-1:0] shadow [0:(1<<AW)-1];

  always #4 clk = ~clk;

  lane_rmw_ctrl #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // Entry: {write, addr, be, data}
  localparam logic [78:0] VEC [0:NV-1] = '{
    {1'b1, 6'd0,  8'hFF, 64'h1111111111111111},
    {1'b1, 6'd1,  8'hFF, 64'h2222222222222222},
    {1'b1, 6'd5,  8'hFF, 64'h0123456789ABCDEF},
    {1'b0, 6'd5,  8'h00, 64'h0},
    {1'b1, 6'd5,  8'h01, 64'hFFFFFFFFFFFFFFAA},
    {1'b0, 6'd5,  8'h00, 64'h0},
    {1'b1, 6'd5,  8'h80, 64'h55000000000000FF},
    {1'b0, 6'd5,  8'h00, 64'h0},
    {1'b1, 6'd0,  8'h0F, 64'hDEADBEEFCAFEF00D},
    {1'b0, 6'd0,  8'h00, 64'h0},
    {1'b1, 6'd1,  8'h00, 64'hFFFFFFFFFFFFFFFF},
    {1'b0, 6'd1,  8'h00, 64'h0},
    {1'b1, 6'd1,  8'h3C, 64'h0011223344556677},
    {1'b0, 6'd1,  8'h00, 64'h0},
    {1'b1, 6'd63, 8'hFF, 64'hA5A5A5A5A5A5A5A5},
    {1'b0, 6'd63, 8'h00, 64'h0}
  };

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [AW-1:0] a, input logic [7:0] be, input logic [DW-1:0] d);
    for (int i = 0; i < 8; i++)
      if (be[i]) shadow[a][8*i +: 8] = d[8*i +: 8];
  endtask

  // Issue one request, wait for it to finish, report busy cycles, responses, data
  task automatic run_req(input logic wr, input logic [AW-1:0] a, input logic [7:0] be,
                         input logic [DW-1:0] d, output int busy, output int rsps,
                         output logic [DW-1:0] rd);
    busy = 0; rsps = 0; rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      if (rsp_valid) rsps++;
      @(negedge clk);
      if (rsp_valid) begin rsps++; rd = rsp_rdata; end
      @(negedge clk);
      if (rsp_valid) rsps++;
    end else begin
      for (int k = 0; k < 6; k++) begin
        if (rsp_valid) rsps++;
        if (!req_ready) busy++;
        @(negedge clk);
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL WDOG actual=%0d expected<%0d", cyc, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int busy, rsps, wait_n;
    logic [DW-1:0] rd;
    for (int i = 0; i < (1<<AW); i++) shadow[i] = '0;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready === 1'b1, "R1 ready after reset", {63'd0, req_ready}, 64'd1);
    chk(rsp_valid === 1'b0, "R1 rsp after reset", {63'd0, rsp_valid}, 64'd0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic wr;
      logic [AW-1:0] a;
      logic [7:0] be;
      logic [DW-1:0] d;
      {wr, a, be, d} = VEC[v];
      run_req(wr, a, be, d, busy, rsps, rd);
      if (wr) begin
        model_write(a, be, d);
        if (be == 8'hFF)
          chk(busy == 1, "R2 full write busy cycles", 64'(busy), 64'd1);
        else if (be == 8'h00)
          chk(busy == 0, "R6 empty write busy cycles", 64'(busy), 64'd0);
        else
          chk(busy == 3, "R4 partial write busy cycles", 64'(busy), 64'd3);
        chk(rsps == 0, "R8 write response count", 64'(rsps), 64'd0);
      end else begin
        chk(rsps == 1, "R7 read pulse count", 64'(rsps), 64'd1);
        chk(rd === shadow[a], "R3 R6 R7 read data", rd, shadow[a]);
      end
    end

    // R9: other words untouched by writes elsewhere
    run_req(1'b0, 6'd5, 8'h00, '0, busy, rsps, rd);
    chk(rd === 64'h5523456789ABCDAA, "R9 word 5 intact", rd, 64'h5523456789ABCDAA);
    run_req(1'b0, 6'd0, 8'h00, '0, busy, rsps, rd);
    chk(rd === 64'h11111111CAFEF00D, "R9 word 0 intact", rd, 64'h11111111CAFEF00D);

    // R5: read held at the port during a partial write
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd5; req_be = 8'h02; req_wdata = 64'h0000000000007700;
    @(posedge clk);
    @(negedge clk);
    model_write(6'd5, 8'h02, 64'h0000000000007700);
    req_write = 1'b0; req_be = 8'h00; req_wdata = '0;
    wait_n = 0;
    while (!req_ready) begin wait_n++; @(negedge clk); end
    chk(wait_n == 3, "R5 held request wait", 64'(wait_n), 64'd3);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R5 held read answered", {63'd0, rsp_valid}, 64'd1);
    chk(rsp_rdata === shadow[5], "R5 held read sees update", rsp_rdata, shadow[5]);

    // R1: reset in the middle of a partial write returns to ready
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd2; req_be = 8'h10; req_wdata = '1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 ready after mid-op reset",
        {62'd0, req_ready, rsp_valid}, 64'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule